// File: doc/BRIEF.md
# Circular Sample Buffer Streamer

This block plays out 32-bit words from a fixed ring of on-chip sample buffers toward a serializer. Reading walks buffer 0, then 1, and so on through the last buffer, and then wraps back to buffer 0 with no end. Each word leaves on a valid/ready stream. When the final word of a buffer has been taken, the block raises a one-cycle completion pulse that names the buffer, and it appends that buffer's index to a completion queue. The queue is as deep as the ring.

A producer pops indices from the completion queue and refills the buffer it popped last. It writes words one at a time, starting at index 0. Ownership is never checked. The reader goes on cycling through whatever each buffer holds, so a buffer that was not refilled is played again. If the producer falls behind and the queue is full when a new completion arrives, the oldest entry is discarded to make room.

A start pulse clears the queue and pending events and rewinds the reader to the first word of buffer 0 before streaming begins. A stop pulse halts the walk, drops the stream valid and clears the queue. Buffer sizes and counts are parameters. `NBUF` is 8 and `WORDS` is 255 by default, and 1023-word buffers are a legal setting.

Top module: `ring_streamer`

## Requirements
- R1: Under reset, `s_valid`, `cq_valid` and `done_evt` are 0. Any buffer word that has not been written since reset streams out as 0.
- R2: While running, words leave in the order word 0 to `WORDS`-1 of buffer b, then word 0 of buffer b+1. Buffer `NBUF`-1 is followed by buffer 0. A word advances only on a cycle with both `s_valid` and `s_ready` high.
- R3: On the clock edge that accepts the last word of buffer b, `done_evt` goes high for one cycle and `done_idx` becomes b. The completion queue gains b on that same edge.
- R4: The completion queue is first-in first-out and holds up to `NBUF` entries. `cq_valid` is 1 while the queue is not empty, and `cq_idx` shows the oldest entry. A cycle with `cq_pop` and `cq_valid` both high removes that entry. A pop on an empty queue has no effect.
- R5: When a completion arrives at a full queue with no pop in the same cycle, the oldest entry is discarded. The queue then holds the `NBUF` most recent completions in order.
- R6: A pop makes the popped index the producer's target buffer and resets its write count to 0. A write (`wr_en`) is accepted only if `wr_idx` equals the number of writes accepted since that pop and that number is below `WORDS`. An accepted word is played on later passes over that buffer.
- R7: Writes are rejected, with no effect, in two cases: before the first pop after reset, and while running when the target buffer is the buffer being read.
- R8: Buffer contents persist. Every lap replays each buffer's latest contents whether or not it was refilled.
- R9: `start` clears the queue and `done_evt`. On the next cycle `s_valid` is 1 and word 0 of buffer 0 is presented. Pops are ignored in that cycle.
- R10: `stop` takes priority over `start`. On the next cycle `s_valid` is 0, the queue is empty, `done_evt` is 0 and the read position is held. Pops are ignored in that cycle.
- R11: While `s_valid` is high, `s_ready` is low and neither `start` nor `stop` is high, the next cycle keeps `s_valid` high and `s_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clear queue and events, rewind, begin streaming |
| stop | input | 1 | Halt streaming and clear queue |
| wr_en | input | 1 | Producer write request |
| wr_idx | input | $clog2(WORDS) | Word index of the write |
| wr_data | input | W | Word to store |
| cq_valid | output | 1 | Completion queue not empty |
| cq_idx | output | $clog2(NBUF) | Oldest completed buffer index |
| cq_pop | input | 1 | Remove the oldest queue entry |
| done_evt | output | 1 | One-cycle buffer completion pulse |
| done_idx | output | $clog2(NBUF) | Buffer that completed |
| s_valid | output | 1 | Stream word valid |
| s_data | output | W | Stream word |
| s_ready | input | 1 | Serializer accepts the word |

## Verification
The bench builds the block with four buffers of three words each. With this setting, a full lap takes twelve transfers and the queue overflows after only four completions, so wrap-around, discard of the oldest entry and replay of stale buffers all occur within a few dozen cycles. The bench runs a cycle-accurate model of the requirements and compares every output on every cycle. The stimulus is a directed sequence of out-of-order and out-of-range writes, a write that collides with the buffer being read, and stop/start sequences, followed by a long pseudo-random mix of ready, pop, write, start and stop.

// File: rtl/ring_streamer.sv
module ring_streamer #(
  parameter int NBUF  = 8,
  parameter int WORDS = 255,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     stop,
  input  logic                     wr_en,
  input  logic [$clog2(WORDS)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  output logic                     cq_valid,
  output logic [$clog2(NBUF)-1:0]  cq_idx,
  input  logic                     cq_pop,
  output logic                     done_evt,
  output logic [$clog2(NBUF)-1:0]  done_idx,
  output logic                     s_valid,
  output logic [W-1:0]             s_data,
  input  logic                     s_ready
);
  localparam int BW = $clog2(NBUF);
  localparam int IW = $clog2(WORDS);
  localparam int HW = $clog2(WORDS + 1);
  localparam int CW = $clog2(NBUF + 1);

  logic [W-1:0]  mem [NBUF][WORDS];
  logic [HW-1:0] hwm [NBUF];
  logic [BW-1:0] q   [NBUF];

  logic          running, have;
  logic [BW-1:0] rd_buf, pr_buf, qh, tail;
  logic [IW-1:0] rd_idx;
  logic [HW-1:0] fill;
  logic [CW-1:0] qc;
  logic [CW:0]   tsum;

  function automatic logic [BW-1:0] nxt(input logic [BW-1:0] v);
    return (v == BW'(NBUF - 1)) ? '0 : v + 1'b1;
  endfunction

  wire hs    = running && s_ready;
  wire last  = hs && (rd_idx == IW'(WORDS - 1));
  wire full  = (qc == CW'(NBUF));
  wire pop   = cq_pop && (qc != '0) && !stop && !start;
  wire push  = last && !stop && !start;
  wire wr_ok = wr_en && have && (HW'(wr_idx) == fill) && (fill < HW'(WORDS))
               && !(running && (rd_buf == pr_buf));

  assign s_valid  = running;
  assign s_data   = (HW'(rd_idx) < hwm[rd_buf]) ? mem[rd_buf][rd_idx] : '0;
  assign cq_valid = (qc != '0);
  assign cq_idx   = q[qh];

  always_comb begin
    tsum = (CW+1)'(qc) + (CW+1)'(qh);
    tail = (tsum >= (CW+1)'(NBUF)) ? BW'(tsum - (CW+1)'(NBUF)) : BW'(tsum);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[pr_buf][IW'(fill)] <= wr_data;
    if (push) q[(full && !pop) ? qh : tail] <= rd_buf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      rd_buf   <= '0;
      rd_idx   <= '0;
      qh       <= '0;
      qc       <= '0;
      done_evt <= 1'b0;
      done_idx <= '0;
      have     <= 1'b0;
      pr_buf   <= '0;
      fill     <= '0;
      for (int i = 0; i < NBUF; i++) hwm[i] <= '0;
    end else begin
      if (stop) begin
        running  <= 1'b0;
        qh       <= '0;
        qc       <= '0;
        done_evt <= 1'b0;
      end else if (start) begin
        running  <= 1'b1;
        rd_buf   <= '0;
        rd_idx   <= '0;
        qh       <= '0;
        qc       <= '0;
        done_evt <= 1'b0;
      end else begin
        done_evt <= last;
        if (last) begin
          done_idx <= rd_buf;
          rd_idx   <= '0;
          rd_buf   <= nxt(rd_buf);
        end else if (hs) begin
          rd_idx <= rd_idx + 1'b1;
        end
        if (last) begin
          if (pop || full) qh <= nxt(qh);
          else             qc <= qc + 1'b1;
        end else if (pop) begin
          qh <= nxt(qh);
          qc <= qc - 1'b1;
        end
      end
      if (wr_ok) begin
        fill <= fill + 1'b1;
        if (hwm[pr_buf] <= fill) hwm[pr_buf] <= fill + 1'b1;
      end
      if (pop) begin
        have   <= 1'b1;
        pr_buf <= q[qh];
        fill   <= '0;
      end
    end
  end
endmodule

// File: rtl/ring_streamer_chk.sv
module ring_streamer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         stop,
  input logic         s_valid,
  input logic         s_ready,
  input logic [W-1:0] s_data,
  input logic         done_evt,
  input logic         cq_valid
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready && !start && !stop) |=> (s_valid && $stable(s_data))); // R11
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!s_valid && !cq_valid && !done_evt)); // R10
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (s_valid && !cq_valid && !done_evt)); // R9
  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> $past(s_valid && s_ready)); // R3
  AST_DONE_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> cq_valid); // R4
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !done_evt); // R2
endmodule

bind ring_streamer ring_streamer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
  .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
  .done_evt(done_evt), .cq_valid(cq_valid)
);

// File: tb/ring_streamer_tb.sv
module ring_streamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int WD = 3;
  localparam int BW = $clog2(NB);
  localparam int IW = $clog2(WD);

  logic clk = 0, rst_n = 0;
  logic st = 0, sp = 0, wen = 0, pop = 0, rdy = 0;
  logic [IW-1:0] widx = '0;
  logic [31:0] wdat = '0;
  logic cq_valid, done_evt, s_valid;
  logic [BW-1:0] cq_idx, done_idx;
  logic [31:0] s_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_streamer #(.NBUF(NB), .WORDS(WD), .W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st), .stop(sp),
    .wr_en(wen), .wr_idx(widx), .wr_data(wdat),
    .cq_valid(cq_valid), .cq_idx(cq_idx), .cq_pop(pop),
    .done_evt(done_evt), .done_idx(done_idx),
    .s_valid(s_valid), .s_data(s_data), .s_ready(rdy)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R2";
  logic [15:0] lf = 16'hACE1;

  int mmem [NB][WD];
  int mhwm [NB];
  int mq [NB];
  int mrun = 0, mrb = 0, mrw = 0, mqh = 0, mqc = 0, mhave = 0, mpb = 0, mfp = 0;
  int mdevt = 0, mdidx = 0;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    chk("R10 s_valid", 32'(s_valid), 32'(mrun));
    if (mrun != 0)
      chk(tag, s_data, (mrw < mhwm[mrb]) ? 32'(mmem[mrb][mrw]) : 32'h0);
    chk("R4 cq_valid", 32'(cq_valid), 32'(mqc > 0));
    if (mqc > 0) chk("R5 cq_idx", 32'(cq_idx), 32'(mq[mqh]));
    chk("R3 done_evt", 32'(done_evt), 32'(mdevt));
    if (mdevt != 0) chk("R3 done_idx", 32'(done_idx), 32'(mdidx));
  endtask

  task automatic model_edge();
    bit hs, lastw, mpop, wacc;
    int hq;
    hs    = (mrun != 0) && rdy;
    lastw = hs && (mrw == WD - 1);
    mpop  = pop && (mqc > 0) && !sp && !st;
    wacc  = wen && (mhave != 0) && (int'(widx) == mfp) && (mfp < WD) && !((mrun != 0) && (mrb == mpb));
    hq    = mq[mqh];
    if (wacc) begin
      mmem[mpb][mfp] = int'(wdat);
      if (mhwm[mpb] <= mfp) mhwm[mpb] = mfp + 1;
      mfp = mfp + 1;
    end
    if (sp) begin
      mrun = 0; mqc = 0; mqh = 0; mdevt = 0;
    end else if (st) begin
      mrun = 1; mrb = 0; mrw = 0; mqc = 0; mqh = 0; mdevt = 0;
    end else begin
      mdevt = lastw;
      if (mpop) begin mqh = (mqh + 1) % NB; mqc--; end
      if (lastw) begin
        mdidx = mrb;
        if (mqc == NB) begin mqh = (mqh + 1) % NB; mqc--; end
        mq[(mqh + mqc) % NB] = mrb;
        mqc++;
        mrw = 0;
        mrb = (mrb + 1) % NB;
      end else if (hs) mrw++;
    end
    if (mpop) begin mhave = 1; mpb = hq; mfp = 0; end
  endtask

  task automatic step();
    check_outputs();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int b = 0; b < NB; b++) begin
      mhwm[b] = 0; mq[b] = 0;
      for (int w = 0; w < WD; w++) mmem[b][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R1 s_valid at reset", 32'(s_valid), 0);
    chk("R1 cq_valid at reset", 32'(cq_valid), 0);
    chk("R1 done_evt at reset", 32'(done_evt), 0);

    tag = "R7 write before first pop";
    wen = 1; widx = '0; wdat = 32'h5A5A0001;
    step(); step();
    wen = 0;
    st = 1; step(); st = 0;

    rdy = 1;
    tag = "R1 unwritten word";
    repeat (WD * NB) step();
    tag = "R2 order and wrap";
    repeat (WD * (NB + 2)) step();

    rdy = 0;
    tag = "R5 drop oldest";
    for (int i = 0; i <= NB; i++) begin
      pop = 1; step(); pop = 0; step();
    end

    tag = "R6 sequential write";
    for (int i = 0; i < 6; i++) begin
      wen = 1;
      widx = (i == 0) ? IW'(1) : (i == 1) ? IW'(0) : (i == 2) ? IW'(1) :
             (i == 3) ? IW'(1) : (i == 4) ? IW'(2) : IW'(3);
      wdat = 32'hA0000 + 32'(i);
      step();
    end
    wen = 0;
    rdy = 1;
    repeat (WD * NB) step();
    tag = "R8 stale replay";
    repeat (WD * NB) step();

    tag = "R11 stall";
    for (int i = 0; i < 60; i++) begin
      rdy = lf[0] & lf[3];
      step();
    end

    tag = "R7 write to buffer in play";
    rdy = 0;
    if (mqc > 0) begin pop = 1; step(); pop = 0; end
    rdy = 1;
    for (int i = 0; i < 4 * NB * WD && mrb != mpb; i++) step();
    rdy = 0;
    for (int i = 0; i < 3; i++) begin
      wen = 1; widx = IW'(mfp); wdat = 32'hBEEF0000 + 32'(i);
      step();
    end
    wen = 0;
    rdy = 1;
    repeat (WD * NB) step();

    tag = "R10 stop";
    sp = 1; step(); sp = 0;
    pop = 1; step(); pop = 0;
    repeat (3) step();
    tag = "R9 start rewind";
    st = 1; sp = 0; step(); st = 0;
    repeat (WD * NB) step();
    st = 1; sp = 1; step(); st = 0; sp = 0;
    st = 1; step(); st = 0;

    tag = "R4 mixed traffic";
    for (int i = 0; i < 3000; i++) begin
      rdy  = lf[0] | lf[1];
      pop  = lf[2] & lf[3];
      wen  = lf[4];
      widx = lf[5] ? IW'(mfp) : lf[7:6];
      wdat = {lf, ~lf};
      st   = (lf[15:10] == 6'd0);
      sp   = (lf[15:9] == 7'd1);
      step();
    end
    st = 0; sp = 0; wen = 0; pop = 0; rdy = 0;
    step();
    summary();
  end
endmodule